// File: doc/BRIEF.md
# Fault Latch and Pulse-Coded Error Pin Driver

This block gathers the fault reports of a sine/cosine interpolator (signal amplitude, input frequency, configuration, supply undervoltage and a resolution step-back warning) and keeps each one stored until the host has read the next sensor data word. It drives a shared, open-drain error pin. A different low/high duty pattern on that pin stands for each fault class, so a plain scope or a slow controller can tell the faults apart. Another device can also pull the pin low. That level is sensed back and treated as a system error.

A two-bit error field goes to the serial position interface in one of two encodings. The standard encoding gives the fault class. The alternate encoding gives a separate "no error" bit and a "no warning" bit. The block also tells the serial interface when the data line has to be held high, which happens while the configuration is invalid or the supply is low. The pin pattern for a fault stays up for a minimum display time after the fault goes away, unless a readout clears it first. All timing is set in clock cycles through parameters.

Top module: `fault_pwm_indicator`

## Requirements
- R1: After reset, and whenever no fault is stored, `pin_drive_low` is 0 and `err_bits` is 2'b11 in both encodings.
- R2: A reported amplitude fault with `ampl_rpt_en`=1 makes `pin_drive_low` 1 for 3/4 of every `PWM_PERIOD` cycles. With `ampl_rpt_en`=0 the pin is not driven for it.
- R3: A frequency fault counts only when `resolution` >= `FREQ_MIN_RES`. When it counts and `freq_rpt_en`=1, `pin_drive_low` is 1 for half of every `PWM_PERIOD` cycles. Below that resolution it affects neither the pin nor `err_bits`.
- R4: `flt_cfg` or `flt_uv` holds `pin_drive_low` at 1 continuously, and no enable input can switch this off.
- R5: When several sources are shown at once, the pin pattern priority is constant low first, then the amplitude pattern, then the frequency pattern.
- R6: A low `pin_sense` while the block is not driving the pin, and did not drive it the cycle before, is stored as a system error.
- R7: With `alt_code`=0, `err_bits` reads 2'b00 for a system error, else 2'b01 for amplitude, else 2'b10 for frequency, else 2'b11.
- R8: With `alt_code`=1, `err_bits[1]` is 0 when any amplitude, frequency or system error is stored, and `err_bits[0]` is 0 when a step-back warning is stored.
- R9: Stored errors remain after their source goes away and are cleared by a `readout_done` pulse. A source that is still active during that pulse stays stored.
- R10: The pin pattern of a source lasts `HOLD_CYCLES` cycles after the source was last active, and a `readout_done` pulse ends it early.
- R11: `data_line_hold` is 1 exactly while `flt_cfg` or `flt_uv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_ampl | input | 1 | Amplitude out of range |
| flt_freq | input | 1 | Input frequency too high |
| flt_cfg | input | 1 | Configuring or configuration invalid |
| flt_uv | input | 1 | Supply undervoltage |
| flt_warn | input | 1 | Resolution step-back warning |
| ampl_rpt_en | input | 1 | Show amplitude faults on the pin |
| freq_rpt_en | input | 1 | Show frequency faults on the pin |
| alt_code | input | 1 | 0: fault-class bits, 1: error/warning bits |
| resolution | input | RES_W | Current interpolation resolution |
| readout_done | input | 1 | Pulse: sensor data has been sent |
| pin_sense | input | 1 | Synchronized level read back from the error pin |
| pin_drive_low | output | 1 | 1 pulls the error pin low |
| err_bits | output | 2 | Error field for the serial interface, [1] sent first |
| data_line_hold | output | 1 | Hold the serial data line high |

## Verification
A table walks single faults, pairs of faults and faults that are masked, in both encodings. For each case it checks the error field and counts the driven-low cycles over one full PWM period. A count of 0, 4, 6 or 8 out of 8 separates the idle, frequency, amplitude and constant-low patterns whatever the phase. Resolutions 15 and 16 are both tried, which shows the frequency gate works at its boundary. An external pull-low is tried alone and together with an amplitude fault, which checks the sense blanking and the priority of the system code. Directed tests cover storage after the source is gone, a clear that lands while a fault is still active, the end of the display window and its early end on readout, and reset in the middle of a run.

// File: rtl/fault_ind_pkg.sv
// Shared types for the fault indicator.
// Assumes: nothing beyond the standard.
package fault_ind_pkg;

    // Pattern shown on the error pin, in rising priority.
    typedef enum logic [1:0] {
        PIN_IDLE = 2'd0,
        PIN_FREQ = 2'd1,
        PIN_AMPL = 2'd2,
        PIN_HARD = 2'd3
    } pin_mode_e;

    // Indices into the stored-error vector.
    localparam int unsigned LAT_AMPL = 0;
    localparam int unsigned LAT_FREQ = 1;
    localparam int unsigned LAT_SYS  = 2;
    localparam int unsigned LAT_WARN = 3;
    localparam int unsigned LAT_N    = 4;

    // Indices into the pin-display source vector.
    localparam int unsigned DSP_HARD = 0;
    localparam int unsigned DSP_AMPL = 1;
    localparam int unsigned DSP_FREQ = 2;
    localparam int unsigned DSP_N    = 3;

endpackage

// File: rtl/err_latch_bank.sv
// Sticky error flags, one per source, cleared by a readout pulse.
// Assumes: a source that is active in the clearing cycle wins over the clear.
module err_latch_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         clr,
    output logic [N-1:0] flag
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Set on the source, hold, drop on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag[g] <= 1'b0;
            else        flag[g] <= src[g] | (flag[g] & ~clr);
        end
    end

    // A live source must be stored on the next edge, clear or not.
    assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0) |=> ((flag & $past(src)) == $past(src)))
        else $error("assert_set_wins_R9");

endmodule

// File: rtl/fault_hold_timer.sv
// Keeps a pin-display source visible for HOLD cycles after it was last active.
// Assumes: HOLD >= 1; clear takes effect only when the source is idle.
module fault_hold_timer #(
    parameter int unsigned HOLD = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    output logic active
);

    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    logic [CW-1:0] remain;

    // Reload while the source is seen, count down after, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (src)          remain <= HOLD_V;
        else if (clr)          remain <= '0;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

    assert property (@(posedge clk) disable iff (!rst_n)
        src |=> active)
        else $error("assert_reload_R10");

    assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !src) |=> !active)
        else $error("assert_early_clear_R10");

endmodule

// File: rtl/pin_pwm_driver.sv
// Turns the selected pin mode into a registered drive-low waveform.
// Assumes: PERIOD >= 4, so both duty fractions come out whole and nonzero.
module pin_pwm_driver
    import fault_ind_pkg::*;
#(
    parameter int unsigned PERIOD = 50000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    output logic      drive_low
);

    localparam int unsigned PW = $clog2(PERIOD);
    localparam logic [PW-1:0] LAST_V     = PW'(PERIOD - 1);
    localparam logic [PW-1:0] AMPL_LOW_V = PW'((PERIOD * 3) / 4);
    localparam logic [PW-1:0] FREQ_LOW_V = PW'(PERIOD / 2);

    logic [PW-1:0] phase;
    logic          want_low;

    // Free-running phase counter over one period.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST_V) phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    // Low share of the period for each mode.
    always_comb begin
        unique case (mode)
            PIN_HARD: want_low = 1'b1;
            PIN_AMPL: want_low = (phase < AMPL_LOW_V);
            PIN_FREQ: want_low = (phase < FREQ_LOW_V);
            default:  want_low = 1'b0;
        endcase
    end

    // Register the output so the pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_low <= 1'b0;
        else        drive_low <= want_low;
    end

    assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST_V)
        else $error("assert_phase_range_R2");

    assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_HARD) |=> drive_low)
        else $error("assert_hard_low_R4");

endmodule

// File: rtl/err_bits_encoder.sv
// Maps the stored errors onto the two-bit serial error field.
// Assumes: bit [1] is sent first; the flag indices come from the package.
module err_bits_encoder
    import fault_ind_pkg::*;
(
    input  logic [LAT_N-1:0] flag,
    input  logic             alt_code,
    output logic [1:0]       bits
);

    // Class code in standard mode, error/warning flags in alternate mode.
    always_comb begin
        if (alt_code) begin
            bits[1] = ~(flag[LAT_AMPL] | flag[LAT_FREQ] | flag[LAT_SYS]);
            bits[0] = ~flag[LAT_WARN];
        end else if (flag[LAT_SYS]) begin
            bits = 2'b00;
        end else if (flag[LAT_AMPL]) begin
            bits = 2'b01;
        end else if (flag[LAT_FREQ]) begin
            bits = 2'b10;
        end else begin
            bits = 2'b11;
        end
    end

endmodule

// File: rtl/fault_pwm_indicator.sv
// Fault latch and pulse-coded error pin driver.
// Gathers fault sources, stores them until readout, drives the open-drain
// error pin with a per-class duty pattern and builds the serial error field.
// Assumes: pin_sense is already synchronized to clk and reads the pin one
// cycle after a release at the latest (covered by one cycle of blanking).
module fault_pwm_indicator
    import fault_ind_pkg::*;
#(
    parameter int unsigned PWM_PERIOD   = 50000,
    parameter int unsigned HOLD_CYCLES  = 500000,
    parameter int unsigned RES_W        = 5,
    parameter int unsigned FREQ_MIN_RES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_ampl,
    input  logic             flt_freq,
    input  logic             flt_cfg,
    input  logic             flt_uv,
    input  logic             flt_warn,
    input  logic             ampl_rpt_en,
    input  logic             freq_rpt_en,
    input  logic             alt_code,
    input  logic [RES_W-1:0] resolution,
    input  logic             readout_done,
    input  logic             pin_sense,
    output logic             pin_drive_low,
    output logic [1:0]       err_bits,
    output logic             data_line_hold
);

    localparam logic [RES_W-1:0] FREQ_MIN_V = RES_W'(FREQ_MIN_RES);

    logic              freq_ok;
    logic              drive_prev;
    logic              ext_now;
    logic [LAT_N-1:0]  lat_src;
    logic [LAT_N-1:0]  lat_flag;
    logic [DSP_N-1:0]  dsp_src;
    logic [DSP_N-1:0]  dsp_on;
    pin_mode_e         mode;

    // Frequency monitoring is only valid at high enough resolution.
    assign freq_ok = flt_freq && (resolution >= FREQ_MIN_V);

    // Remember last cycle's drive to blank the release edge.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_prev <= 1'b0;
        else        drive_prev <= pin_drive_low;
    end

    // Pin low while released by this block means someone else pulls it.
    assign ext_now = !pin_sense && !pin_drive_low && !drive_prev;

    // Sources of the stored error flags.
    always_comb begin
        lat_src           = '0;
        lat_src[LAT_AMPL] = flt_ampl;
        lat_src[LAT_FREQ] = freq_ok;
        lat_src[LAT_SYS]  = ext_now;
        lat_src[LAT_WARN] = flt_warn;
    end

    err_latch_bank #(.N(LAT_N)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (lat_src),
        .clr  (readout_done),
        .flag (lat_flag)
    );

    // Sources of the pin display, after the report enables.
    always_comb begin
        dsp_src           = '0;
        dsp_src[DSP_HARD] = flt_cfg | flt_uv;
        dsp_src[DSP_AMPL] = flt_ampl & ampl_rpt_en;
        dsp_src[DSP_FREQ] = freq_ok & freq_rpt_en;
    end

    for (genvar g = 0; g < DSP_N; g++) begin : g_hold
        fault_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (dsp_src[g]),
            .clr   (readout_done),
            .active(dsp_on[g])
        );
    end

    // Pick the highest-priority pattern on display.
    always_comb begin
        if (dsp_on[DSP_HARD])      mode = PIN_HARD;
        else if (dsp_on[DSP_AMPL]) mode = PIN_AMPL;
        else if (dsp_on[DSP_FREQ]) mode = PIN_FREQ;
        else                       mode = PIN_IDLE;
    end

    pin_pwm_driver #(.PERIOD(PWM_PERIOD)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .drive_low(pin_drive_low)
    );

    err_bits_encoder u_enc (
        .flag    (lat_flag),
        .alt_code(alt_code),
        .bits    (err_bits)
    );

    // Serial data line is parked while configuration or supply is bad.
    assign data_line_hold = flt_cfg | flt_uv;

    assert property (@(posedge clk) disable iff (!rst_n)
        (lat_flag == '0) |-> (err_bits == 2'b11))
        else $error("assert_idle_bits_R1");

    assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_on == '0) |=> !pin_drive_low)
        else $error("assert_idle_pin_R1");

    assert property (@(posedge clk) disable iff (!rst_n)
        (readout_done && lat_src == '0) |=> (err_bits == 2'b11))
        else $error("assert_readout_clear_R9");

    assert property (@(posedge clk) disable iff (!rst_n)
        (lat_flag[LAT_SYS] && !alt_code) |-> (err_bits == 2'b00))
        else $error("assert_sys_code_R7");

    assert property (@(posedge clk) disable iff (!rst_n)
        (alt_code && lat_flag[LAT_WARN]) |-> !err_bits[0])
        else $error("assert_warn_bit_R8");

endmodule

// File: tb/fault_pwm_indicator_tb.sv
module fault_pwm_indicator_tb;

    localparam int PER  = 8;
    localparam int HOLD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flt_ampl = 0, flt_freq = 0, flt_cfg = 0, flt_uv = 0, flt_warn = 0;
    logic       ampl_rpt_en = 0, freq_rpt_en = 0, alt_code = 0;
    logic [4:0] resolution = 5'd16;
    logic       readout_done = 0;
    logic       ext_pull = 0;
    logic       pin_sense;
    logic       pin_drive_low;
    logic [1:0] err_bits;
    logic       data_line_hold;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    // Open-drain pin model: low if this block or another device pulls it.
    assign pin_sense = !(pin_drive_low || ext_pull);

    fault_pwm_indicator #(
        .PWM_PERIOD(PER), .HOLD_CYCLES(HOLD), .RES_W(5), .FREQ_MIN_RES(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .flt_ampl(flt_ampl), .flt_freq(flt_freq), .flt_cfg(flt_cfg),
        .flt_uv(flt_uv), .flt_warn(flt_warn),
        .ampl_rpt_en(ampl_rpt_en), .freq_rpt_en(freq_rpt_en),
        .alt_code(alt_code), .resolution(resolution),
        .readout_done(readout_done), .pin_sense(pin_sense),
        .pin_drive_low(pin_drive_low), .err_bits(err_bits),
        .data_line_hold(data_line_hold)
    );

    // {ampl,freq,cfg,uv,warn,ext,aen,fen,alt,res[4:0],bits[1:0],low[3:0]}
    localparam logic [19:0] VEC [0:15] = '{
        {6'b000000, 3'b110, 5'd16, 2'b11, 4'd0},  // R1 idle
        {6'b100000, 3'b100, 5'd16, 2'b01, 4'd6},  // R2 amplitude
        {6'b100000, 3'b000, 5'd16, 2'b01, 4'd0},  // R2 masked
        {6'b010000, 3'b010, 5'd16, 2'b10, 4'd4},  // R3 frequency
        {6'b010000, 3'b010, 5'd15, 2'b11, 4'd0},  // R3 below resolution
        {6'b010000, 3'b000, 5'd20, 2'b10, 4'd0},  // R3 masked
        {6'b110000, 3'b110, 5'd16, 2'b01, 4'd6},  // R5 R7 ampl over freq
        {6'b001000, 3'b000, 5'd16, 2'b11, 4'd8},  // R4 configuration
        {6'b100100, 3'b100, 5'd16, 2'b01, 4'd8},  // R4 R5 undervoltage wins
        {6'b000001, 3'b110, 5'd16, 2'b00, 4'd0},  // R6 external pull
        {6'b100001, 3'b100, 5'd16, 2'b00, 4'd6},  // R6 R7 system over ampl
        {6'b100000, 3'b101, 5'd16, 2'b01, 4'd6},  // R8 alt amplitude
        {6'b000010, 3'b001, 5'd16, 2'b10, 4'd0},  // R8 alt warning
        {6'b010010, 3'b011, 5'd16, 2'b00, 4'd4},  // R8 alt freq plus warning
        {6'b000000, 3'b001, 5'd16, 2'b11, 4'd0},  // R8 alt idle
        {6'b000001, 3'b111, 5'd16, 2'b01, 4'd0}   // R8 alt system
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        repeat (PER) begin
            @(negedge clk);
            if (pin_drive_low) n++;
        end
    endtask

    task automatic drop_all();
        flt_ampl = 0; flt_freq = 0; flt_cfg = 0; flt_uv = 0; flt_warn = 0;
        ext_pull = 0;
    endtask

    task automatic readout();
        readout_done = 1; tick(1); readout_done = 0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int lo;
        tick(3);
        // R1: reset state
        chk("R1 bits in reset", err_bits, 2'b11);
        chk("R1 pin in reset", pin_drive_low, 0);
        rst_n = 1;
        tick(2);
        chk("R1 bits after reset", err_bits, 2'b11);
        count_low(lo);
        chk("R1 pin after reset", lo, 0);

        for (int i = 0; i < 16; i++) begin
            logic [19:0] v;
            v = VEC[i];
            drop_all();
            readout();
            tick(2);
            {flt_ampl, flt_freq, flt_cfg, flt_uv, flt_warn, ext_pull} = v[19:14];
            {ampl_rpt_en, freq_rpt_en, alt_code} = v[13:11];
            resolution = v[10:6];
            tick(3);
            chk($sformatf("R7/R8 bits vector %0d", i), err_bits, v[5:4]);
            chk($sformatf("R11 hold vector %0d", i), data_line_hold,
                v[17] | v[16]);
            count_low(lo);
            chk($sformatf("R2/R3/R4/R5/R6 pin vector %0d", i), lo, v[3:0]);
        end

        // R9: stored after the source goes, pattern gone after hold (R10)
        drop_all(); alt_code = 0; ampl_rpt_en = 1; readout(); tick(2);
        flt_ampl = 1; tick(2); flt_ampl = 0;
        tick(50);
        chk("R9 stored without source", err_bits, 2'b01);
        count_low(lo);
        chk("R10 pattern ends after hold", lo, 0);
        readout(); tick(1);
        chk("R9 cleared by readout", err_bits, 2'b11);

        // R9: source still active during clear stays stored
        flt_ampl = 1; tick(2); readout(); tick(1);
        chk("R9 set wins over clear", err_bits, 2'b01);
        flt_ampl = 0; readout(); tick(1);

        // R10: pattern still shown inside the hold window
        flt_ampl = 1; tick(3); flt_ampl = 0;
        tick(15);
        count_low(lo);
        chk("R10 pattern inside hold", lo, 6);
        tick(30);
        count_low(lo);
        chk("R10 pattern after hold", lo, 0);

        // R10: readout ends the pattern early
        flt_ampl = 1; tick(3); flt_ampl = 0;
        tick(3); readout(); tick(2);
        count_low(lo);
        chk("R10 early end on readout", lo, 0);

        // R4: enables cannot mask the constant low; R11 follows live input
        ampl_rpt_en = 0; freq_rpt_en = 0; flt_uv = 1; #1;
        chk("R11 hold on undervoltage", data_line_hold, 1);
        tick(3);
        count_low(lo);
        chk("R4 constant low unmaskable", lo, 8);

        // R1: reset in the middle of a run
        flt_uv = 0; flt_warn = 1; alt_code = 1; tick(2);
        rst_n = 0; flt_warn = 0; tick(2);
        chk("R1 bits after mid-run reset", err_bits, 2'b11);
        chk("R1 pin after mid-run reset", pin_drive_low, 0);
        rst_n = 1; tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule